// File: doc/BRIEF.md
# Triggered Multi-Hit Capture Buffer

This block records timestamps around an external trigger. Software arms it, and the next trigger latches its coarse and fine time together with a window length. For the window that follows, each event timestamp is turned into a time relative to the trigger. The trigger's own fine part is folded into that time. An event that lands in the window is written to an on-chip memory along with its channel number. The block takes one event per clock cycle.

Capture stops when the window runs out or when the memory fills, whichever happens first. The block then holds its results until a readout request arrives. It streams the stored entries in arrival order over a valid/ready handshake. After the last entry has been accepted it returns to idle, ready to be armed again.

Relative times are given in fine LSB units. The coarse difference is scaled by 2^FINE_W. With the default edge-referenced fine code, the relative time is (event_coarse - trigger_coarse) * 2^FINE_W + (trigger_fine - event_fine). The coarse difference is taken modulo 2^COARSE_W and read as a signed number, so a trigger shortly before the coarse counter wraps still works.

Top module: `mhit_capture`

## Requirements
- R1: After reset the block is idle, with done, full and rd_valid all low.
- R2: A trigger is accepted only while armed. A trigger seen while idle starts no capture. A pulse on arm while idle makes the block armed.
- R3: An accepted event is stored with rd_time = ((ev_coarse - trig_coarse) mod 2^COARSE_W, read as signed) * 2^FINE_W + trig_fine - ev_fine, together with its ev_chan.
- R4: An event whose relative time is negative, or not below win_len * 2^FINE_W, is discarded.
- R5: Events are sampled on the win_len clock edges that follow the edge accepting the trigger. done rises at the last of those edges and stays high until readout starts.
- R6: When the DEPTH-th entry is written, capture ends at that edge with done and full both high. Later events are dropped. full stays low when capture ended because the window expired.
- R7: A rd_start pulse while done is high starts the stream. Entries come out in arrival order, one per edge with rd_valid and rd_ready both high. rd_last marks the final entry. The outputs hold steady while rd_ready is low.
- R8: The handshake on the last entry returns the block to idle. A rd_start with nothing stored returns it to idle directly.
- R9: arm is ignored outside idle. rd_start is ignored outside the done state.
- R10: Events on consecutive clock cycles are all captured, with no gap cycles needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm request, honoured while idle |
| rd_start | input | 1 | Begin streaming stored entries, honoured in done |
| trig_valid | input | 1 | Trigger timestamp present |
| trig_coarse | input | COARSE_W | Trigger coarse time |
| trig_fine | input | FINE_W | Trigger fine time |
| win_len | input | WIN_W | Window length in coarse ticks, latched with the trigger |
| ev_valid | input | 1 | Event timestamp present |
| ev_coarse | input | COARSE_W | Event coarse time |
| ev_fine | input | FINE_W | Event fine time |
| ev_chan | input | CH_W | Channel that produced the event |
| rd_valid | output | 1 | Stream entry available |
| rd_ready | input | 1 | Consumer accepts the entry |
| rd_chan | output | CH_W | Channel of the current entry |
| rd_time | output | WIN_W+FINE_W | Trigger-relative time of the current entry |
| rd_last | output | 1 | Current entry is the final one |
| done | output | 1 | Capture finished, results waiting |
| full | output | 1 | Capture ended because the memory filled |

## Verification
If the capture timer is wrong, done rises on the wrong edge. Events on the window boundary then show up as an entry too many or too few at readout. If the relative-time arithmetic or the boundary filter is wrong, it shows on the first streamed entry that touches it: a bad value, or a rejected event that appears. If the fill or read pointers are wrong, entries come out lost or reordered, rd_last lands on the wrong beat, or the block fails to return to idle. The first handshake after rd_start exposes a bad read pointer, and the final beat exposes a bad fill count.

// File: rtl/mhc_pkg.sv
package mhc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_CAPT  = 3'd2,
      ST_DONE  = 3'd3,
      ST_READ  = 3'd4
   } mhc_state_e;
endpackage

// File: rtl/mhc_reltime.sv
// Trigger-relative time of one event, plus the window acceptance test (R3, R4).
module mhc_reltime #(
   parameter int COARSE_W     = 14,
   parameter int FINE_W       = 6,
   parameter int WIN_W        = 12,
   parameter bit FINE_TO_EDGE = 1'b1
) (
   input  logic [COARSE_W-1:0]     ev_coarse,
   input  logic [FINE_W-1:0]       ev_fine,
   input  logic [COARSE_W-1:0]     trig_coarse,
   input  logic [FINE_W-1:0]       trig_fine,
   input  logic [WIN_W-1:0]        win_q,
   output logic                    keep,
   output logic [WIN_W+FINE_W-1:0] rel_time
);
   localparam int REL_W  = COARSE_W + FINE_W + 1;
   localparam int TIME_W = WIN_W + FINE_W;

   logic [COARSE_W-1:0]     dc;
   logic signed [REL_W-1:0] coarse_part;
   logic signed [REL_W-1:0] tf_x;
   logic signed [REL_W-1:0] ef_x;
   logic signed [REL_W-1:0] fine_part;
   logic signed [REL_W-1:0] rel;
   logic signed [REL_W-1:0] limit;

   always_comb begin
      dc          = ev_coarse - trig_coarse;
      coarse_part = {dc[COARSE_W-1], dc, {FINE_W{1'b0}}};
      tf_x        = {{(REL_W-FINE_W){1'b0}}, trig_fine};
      ef_x        = {{(REL_W-FINE_W){1'b0}}, ev_fine};
   end

   generate
      if (FINE_TO_EDGE) begin : g_edge_ref
         // fine code counts up to the next clock edge: stamp = coarse - fine
         assign fine_part = tf_x - ef_x;
      end else begin : g_start_ref
         // fine code counts from the previous clock edge: stamp = coarse + fine
         assign fine_part = ef_x - tf_x;
      end
   endgenerate

   always_comb begin
      rel      = coarse_part + fine_part;
      limit    = {{(REL_W-TIME_W){1'b0}}, win_q, {FINE_W{1'b0}}};
      keep     = !rel[REL_W-1] && (rel < limit);
      rel_time = rel[TIME_W-1:0];
   end
endmodule

// File: rtl/mhc_store.sv
// Capture memory with a fill counter and a sequential read pointer (R6, R7).
module mhc_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 22
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_adv,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_last,
   output logic                     empty,
   output logic                     last_slot
);
   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW:0]       fill;
   logic [AW-1:0]     rd_ptr;

   always_ff @(posedge clk) begin
      if (wr_en) mem[fill[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         fill   <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en)  fill   <= fill + 1'b1;
         if (rd_adv) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_comb begin
      rd_data   = mem[rd_ptr];
      rd_last   = (({1'b0, rd_ptr}) + (AW+1)'(1)) == fill;
      empty     = (fill == '0);
      last_slot = (fill == (AW+1)'(DEPTH-1));
   end
endmodule

// File: rtl/mhc_ctrl.sv
// Sequencing: idle, armed, capturing, done, readout (R2, R5, R6, R8, R9).
module mhc_ctrl
   import mhc_pkg::*;
#(
   parameter int WIN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             trig_valid,
   input  logic             rd_start,
   input  logic             ev_valid,
   input  logic             keep,
   input  logic             last_slot,
   input  logic             empty,
   input  logic             rd_fire,
   input  logic             rd_last,
   input  logic [WIN_W-1:0] win_q,
   output mhc_state_e       state,
   output logic             trig_take,
   output logic             wr_en,
   output logic             clear,
   output logic             full_q
);
   logic [WIN_W-1:0] timer;
   logic [WIN_W:0]   timer_nx;
   logic             win_over;

   always_comb begin
      trig_take = (state == ST_ARMED) && trig_valid;
      wr_en     = (state == ST_CAPT) && ev_valid && keep;
      clear     = (state == ST_IDLE) && arm;
      timer_nx  = {1'b0, timer} + 1'b1;
      win_over  = timer_nx >= {1'b0, win_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         timer  <= '0;
         full_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (arm) begin
                  state  <= ST_ARMED;
                  full_q <= 1'b0;
               end
            end
            ST_ARMED: begin
               if (trig_take) begin
                  state <= ST_CAPT;
                  timer <= '0;
               end
            end
            ST_CAPT: begin
               timer <= timer_nx[WIN_W-1:0];
               if (wr_en && last_slot) begin
                  state  <= ST_DONE;
                  full_q <= 1'b1;
               end else if (win_over) begin
                  state <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (rd_start) state <= empty ? ST_IDLE : ST_READ;
            end
            ST_READ: begin
               if (rd_fire && rd_last) begin
                  state  <= ST_IDLE;
                  full_q <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mhit_capture.sv
module mhit_capture
   import mhc_pkg::*;
#(
   parameter int COARSE_W     = 14,
   parameter int FINE_W       = 6,
   parameter int WIN_W        = 12,
   parameter int CH_W         = 4,
   parameter int DEPTH        = 256,
   parameter bit FINE_TO_EDGE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    arm,
   input  logic                    rd_start,
   input  logic                    trig_valid,
   input  logic [COARSE_W-1:0]     trig_coarse,
   input  logic [FINE_W-1:0]       trig_fine,
   input  logic [WIN_W-1:0]        win_len,
   input  logic                    ev_valid,
   input  logic [COARSE_W-1:0]     ev_coarse,
   input  logic [FINE_W-1:0]       ev_fine,
   input  logic [CH_W-1:0]         ev_chan,
   output logic                    rd_valid,
   input  logic                    rd_ready,
   output logic [CH_W-1:0]         rd_chan,
   output logic [WIN_W+FINE_W-1:0] rd_time,
   output logic                    rd_last,
   output logic                    done,
   output logic                    full
);
   localparam int TIME_W = WIN_W + FINE_W;
   localparam int DATA_W = CH_W + TIME_W;

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mhit_capture: DEPTH must be a power of two of at least 2");
   end
   if (WIN_W >= COARSE_W) begin : g_bad_window
      $error("mhit_capture: window must be narrower than the coarse full-scale range");
   end
   if (FINE_W < 1 || CH_W < 1) begin : g_bad_fields
      $error("mhit_capture: FINE_W and CH_W must be at least 1");
   end

   mhc_state_e          state;
   logic                trig_take, wr_en, clear, full_q;
   logic                keep, last_slot, empty, st_last, rd_fire;
   logic [COARSE_W-1:0] tc_q;
   logic [FINE_W-1:0]   tf_q;
   logic [WIN_W-1:0]    win_q;
   logic [TIME_W-1:0]   rel_time;
   logic [DATA_W-1:0]   rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc_q  <= '0;
         tf_q  <= '0;
         win_q <= '0;
      end else if (trig_take) begin
         tc_q  <= trig_coarse;
         tf_q  <= trig_fine;
         win_q <= win_len;
      end
   end

   mhc_reltime #(
      .COARSE_W(COARSE_W), .FINE_W(FINE_W), .WIN_W(WIN_W), .FINE_TO_EDGE(FINE_TO_EDGE)
   ) u_rel (
      .ev_coarse(ev_coarse), .ev_fine(ev_fine),
      .trig_coarse(tc_q), .trig_fine(tf_q), .win_q(win_q),
      .keep(keep), .rel_time(rel_time)
   );

   mhc_ctrl #(.WIN_W(WIN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig_valid(trig_valid),
      .rd_start(rd_start), .ev_valid(ev_valid), .keep(keep),
      .last_slot(last_slot), .empty(empty), .rd_fire(rd_fire),
      .rd_last(st_last), .win_q(win_q), .state(state),
      .trig_take(trig_take), .wr_en(wr_en), .clear(clear), .full_q(full_q)
   );

   mhc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
      .wr_data({ev_chan, rel_time}), .rd_adv(rd_fire), .rd_data(rd_data),
      .rd_last(st_last), .empty(empty), .last_slot(last_slot)
   );

   always_comb begin
      rd_valid = (state == ST_READ);
      rd_fire  = rd_valid && rd_ready;
      rd_chan  = rd_data[DATA_W-1:TIME_W];
      rd_time  = rd_data[TIME_W-1:0];
      rd_last  = rd_valid && st_last;
      done     = (state == ST_DONE);
      full     = full_q;
   end
endmodule

// File: rtl/mhc_checker.sv
module mhc_checker #(
   parameter int CH_W   = 4,
   parameter int TIME_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              rd_start,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [CH_W-1:0]   rd_chan,
   input logic [TIME_W-1:0] rd_time,
   input logic              rd_last,
   input logic              done,
   input logic              full
);
   // R6: full is only shown while results are held or streamed
   p_full_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (done || rd_valid));

   // R7: done and streaming never overlap
   p_done_no_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_valid);

   // R7: a stalled entry stays put
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_time) && $stable(rd_chan)
                                   && $stable(rd_last)));

   // R8: last handshake returns to idle
   p_last_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && rd_last) |=> (!rd_valid && !done && !full));

   // R5: results held until readout is requested
   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd_start) |=> done);

   // R9: arm has no effect while results are held
   p_arm_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && arm && !rd_start) |=> (done && $stable(full)));
endmodule

bind mhit_capture mhc_checker #(.CH_W(CH_W), .TIME_W(WIN_W + FINE_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .arm(arm), .rd_start(rd_start),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_chan(rd_chan),
   .rd_time(rd_time), .rd_last(rd_last), .done(done), .full(full)
);

// File: tb/mhit_capture_tb_top.sv
module mhit_capture_tb_top;
   localparam int COARSE_W = 14;
   localparam int FINE_W   = 6;
   localparam int WIN_W    = 12;
   localparam int CH_W     = 4;
   localparam int DEPTH    = 256;
   localparam int TIME_W   = WIN_W + FINE_W;

   // stimulus/expected table for one capture: trigger coarse 100, fine 20, window 8
   localparam int NV = 8;
   localparam int V_OFF  [NV] = '{0, 0, 3, -1, 7, 8, 8, 2};
   localparam int V_EF   [NV] = '{30, 5, 63, 0, 40, 20, 21, 20};
   localparam int V_KEEP [NV] = '{0, 1, 1, 0, 1, 0, 1, 1};
   localparam int V_EXP  [NV] = '{0, 15, 149, 0, 428, 0, 511, 128};

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                arm = 1'b0, rd_start = 1'b0, trig_valid = 1'b0;
   logic [COARSE_W-1:0] trig_coarse = '0, ev_coarse = '0;
   logic [FINE_W-1:0]   trig_fine = '0, ev_fine = '0;
   logic [WIN_W-1:0]    win_len = '0;
   logic                ev_valid = 1'b0, rd_ready = 1'b0;
   logic [CH_W-1:0]     ev_chan = '0;
   logic                rd_valid, rd_last, done, full;
   logic [CH_W-1:0]     rd_chan;
   logic [TIME_W-1:0]   rd_time;

   int n_chk = 0;
   int n_bad = 0;
   int exp_t [DEPTH];
   int exp_c [DEPTH];
   int n_exp;

   always #2 clk = ~clk;

   mhit_capture #(
      .COARSE_W(COARSE_W), .FINE_W(FINE_W), .WIN_W(WIN_W), .CH_W(CH_W), .DEPTH(DEPTH)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .rd_start(rd_start),
      .trig_valid(trig_valid), .trig_coarse(trig_coarse), .trig_fine(trig_fine),
      .win_len(win_len), .ev_valid(ev_valid), .ev_coarse(ev_coarse),
      .ev_fine(ev_fine), .ev_chan(ev_chan), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_chan(rd_chan), .rd_time(rd_time),
      .rd_last(rd_last), .done(done), .full(full)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_arm();
      arm = 1'b1; @(negedge clk); arm = 1'b0;
   endtask

   task automatic pulse_rd_start();
      rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
   endtask

   task automatic trigger(input int tc, input int tf, input int win);
      trig_valid  = 1'b1;
      trig_coarse = COARSE_W'(tc);
      trig_fine   = FINE_W'(tf);
      win_len     = WIN_W'(win);
      @(negedge clk);
      trig_valid  = 1'b0;
   endtask

   task automatic drive_ev(input int ec, input int ef, input int ch);
      ev_valid  = 1'b1;
      ev_coarse = COARSE_W'(ec);
      ev_fine   = FINE_W'(ef);
      ev_chan   = CH_W'(ch);
      @(negedge clk);
      ev_valid  = 1'b0;
   endtask

   // R7, R8: stream out and compare against exp_t/exp_c, with one stall on the first beat
   task automatic read_expect(input string tag);
      pulse_rd_start();
      for (int i = 0; i < n_exp; i++) begin
         check({tag, " R7 valid"}, int'(rd_valid), 1);
         check({tag, " R7 time"}, int'(rd_time), exp_t[i]);
         check({tag, " R7 chan"}, int'(rd_chan), exp_c[i]);
         check({tag, " R7 last"}, int'(rd_last), (i == n_exp - 1) ? 1 : 0);
         if (i == 0) begin
            rd_ready = 1'b0;
            @(negedge clk);
            check({tag, " R7 stall hold"}, int'(rd_time), exp_t[0]);
         end
         rd_ready = 1'b1;
         @(negedge clk);
         rd_ready = 1'b0;
      end
      check({tag, " R8 idle valid"}, int'(rd_valid), 0);
      check({tag, " R8 idle done"}, int'(done), 0);
      check({tag, " R8 idle full"}, int'(full), 0);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 done", int'(done), 0);
      check("R1 full", int'(full), 0);
      check("R1 rd_valid", int'(rd_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: trigger while idle starts nothing
      trigger(10, 0, 2);
      drive_ev(10, 0, 1);
      repeat (4) @(negedge clk);
      check("R2 idle trigger done", int'(done), 0);
      pulse_rd_start();
      check("R9 rd_start idle", int'(rd_valid), 0);

      // R2, R9: arm, then rd_start in armed is ignored
      pulse_arm();
      pulse_rd_start();
      check("R9 rd_start armed valid", int'(rd_valid), 0);
      check("R9 rd_start armed done", int'(done), 0);

      // R3, R4, R5: table walk
      trigger(100, 20, 8);
      for (int i = 0; i < NV; i++) begin
         drive_ev(100 + V_OFF[i], V_EF[i], i + 1);
         ev_valid = 1'b0;
         if (i < NV - 1) check("R5 not yet done", int'(done), 0);
      end
      check("R5 done at window end", int'(done), 1);
      check("R6 no full on expiry", int'(full), 0);
      n_exp = 0;
      for (int i = 0; i < NV; i++) begin
         if (V_KEEP[i] != 0) begin
            exp_t[n_exp] = V_EXP[i];
            exp_c[n_exp] = i + 1;
            n_exp++;
         end
      end
      read_expect("R3 R4 table");

      // R3: coarse wrap across the counter limit
      pulse_arm();
      trigger(16380, 10, 20);
      drive_ev(2, 50, 9);        // +6 coarse across wrap: 384 + 10 - 50 = 344
      drive_ev(16379, 0, 3);     // one tick before trigger: negative, R4 discard
      repeat (20) @(negedge clk);
      check("R5 wrap done", int'(done), 1);
      n_exp = 1; exp_t[0] = 344; exp_c[0] = 9;
      read_expect("R3 wrap");

      // R5, R9: 3-cycle window, arm pulse during capture ignored
      pulse_arm();
      trigger(200, 20, 3);
      drive_ev(200, 0, 0);
      arm = 1'b1;
      drive_ev(200, 1, 1);
      arm = 1'b0;
      check("R5 open after two", int'(done), 0);
      drive_ev(200, 2, 2);
      check("R5 closed after three", int'(done), 1);
      drive_ev(200, 3, 3);
      drive_ev(200, 4, 4);
      n_exp = 3;
      for (int i = 0; i < 3; i++) begin
         exp_t[i] = 20 - i;
         exp_c[i] = i;
      end
      read_expect("R5 R9 window");

      // R6, R10: back-to-back events overfill the memory
      pulse_arm();
      trigger(50, 0, 1000);
      for (int k = 0; k < DEPTH + 4; k++) begin
         ev_valid  = 1'b1;
         ev_coarse = COARSE_W'(51);
         ev_fine   = FINE_W'(k % 64);
         ev_chan   = CH_W'(k % 16);
         @(negedge clk);
         if (k == DEPTH - 2) check("R6 not full early", int'(done), 0);
      end
      ev_valid = 1'b0;
      check("R6 done on fill", int'(done), 1);
      check("R6 full flag", int'(full), 1);
      n_exp = DEPTH;
      for (int i = 0; i < DEPTH; i++) begin
         exp_t[i] = 64 - (i % 64);
         exp_c[i] = i % 16;
      end
      read_expect("R6 R10 fill");

      // R8: empty capture, rd_start returns straight to idle
      pulse_arm();
      trigger(300, 0, 2);
      repeat (3) @(negedge clk);
      check("R8 empty done", int'(done), 1);
      check("R8 empty full", int'(full), 0);
      pulse_rd_start();
      check("R8 empty idle done", int'(done), 0);
      check("R8 empty idle valid", int'(rd_valid), 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule